// File: doc/BRIEF.md
# Free-Queue Virtual Channel Allocator

This block hands out output virtual channels (VCs) to the input VCs of an on-chip router that has `P` ports and `V` VCs per port. Each input VC that holds a packet head presents a request together with the one output port that routing chose for it. Any VC on that port is acceptable. Every output port keeps a queue of the identifiers of its free VCs. The head of that queue is the port's next candidate, so the allocator does not need a stage that picks among output VCs. It only needs one round-robin arbiter per output port over all `P*V` input VCs.

A grant pops the head of the port's queue and records the port and the VC in the winner's allocation state. That state stays until the input VC reports that its tail flit has left. At that point the VC it held is appended to the tail of its port's free queue. Grant and release are combinational in the cycle they are presented, and their effect on the state is visible from the next cycle. Each input VC has a two-state machine: `VS_IDLE` and `VS_ACTIVE`. A grant is the transition `T_GRANT` from `VS_IDLE` to `VS_ACTIVE`. A release is the transition `T_RELEASE` from `VS_ACTIVE` back to `VS_IDLE`.

Input VC `i` is numbered `port*V + vc`. Its request port is `req_port[i*PW +: PW]`, where `PW = $clog2(P)`. Its VC fields are `VW = $clog2(V)` bits wide, at `[i*VW +: VW]`. Bit `p*V + k` of `free_head_oh` stands for VC `k` of output port `p`.

Top module: `fqva_top`

## Requirements
- R1: After reset every input VC is idle and every port's free queue holds VCs 0 to V-1 in ascending order. As a result, `free_head_oh` has exactly bit `p*V` set for each port `p`.
- R2: For each port, `free_head_oh[p*V +: V]` is the one-hot code of that port's queue head when the queue is non-empty, and all zero when it is empty.
- R3: `grant[i]` is raised only for an input VC that is requesting and idle, and only when the requested port's queue is non-empty. For a granted VC, `grant_vc[i*VW +: VW]` equals the head VC identifier of the requested port.
- R4: Each output port grants at most one input VC per cycle. A port with an empty queue grants none, and its requests stay pending until a VC is freed.
- R5: After a grant, from the next cycle on, the input VC is busy and `vc_owned` holds the granted VC. The port's queue head advances to the next identifier in the queue.
- R6: A release (`tail_done[i]`) of a busy input VC makes that input VC idle in the next cycle. It also appends the VC it held to the tail of its port's queue, so freed VCs are handed out again in release order.
- R7: A release and a grant on the same port in the same cycle both take effect. The head is popped, the freed VC joins the tail, and the queue length is unchanged. On an empty queue the release is accepted and no grant is made that cycle.
- R8: Each port arbitrates round-robin. After the port grants input VC `i`, the search for the next grant starts at input VC `i+1`, wrapping from `P*V-1` to 0.
- R9: A request from an input VC that is already busy is ignored. It receives no grant and does not affect any queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | P*V | Input VC holds a packet head that wants an output VC |
| req_port | input | P*V*PW | Output port chosen by routing, one field per input VC |
| tail_done | input | P*V | Tail flit of the input VC left; release its output VC (at most one per output port per cycle, busy VCs only) |
| grant | output | P*V | Input VC receives an output VC this cycle |
| grant_vc | output | P*V*VW | Head VC of the requested port; valid where `grant` is set |
| vc_busy | output | P*V | Input VC currently owns an output VC |
| vc_owned | output | P*V*VW | Output VC owned by each busy input VC |
| free_head_oh | output | P*V | One-hot head of each port's free-VC queue |

## Verification
The case to watch is a grant and a release on the same output port in the same cycle, because one queue is popped and pushed at once. The bench provokes it in two ways. First, it drains port 0 with every input VC requesting and then frees one VC per cycle while the requests stay up. Second, it runs a long stretch of random requests and releases in which the two coincide often. A behavioural queue model in the bench predicts the grant, the head mask and the ownership every cycle, and it counts the coincidences so that the case is shown to have occurred.

// File: rtl/fqva_pkg.sv
package fqva_pkg;
    typedef enum logic {
        VS_IDLE   = 1'b0,
        VS_ACTIVE = 1'b1
    } ivc_state_e;
endpackage

// File: rtl/fqva_free_queue.sv
module fqva_free_queue #(
    parameter int V  = 4,
    parameter int VW = $clog2(V)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pop,
    input  logic          push,
    input  logic [VW-1:0] push_id,
    output logic [VW-1:0] head_id,
    output logic          nonempty,
    output logic [V-1:0]  head_oh
);
    localparam int CW = $clog2(V + 1);

    logic [VW-1:0] slot [V];
    logic [VW-1:0] rd_ptr, wr_ptr;
    logic [CW-1:0] count;
    logic          do_pop;

    function automatic logic [VW-1:0] step_ptr(input logic [VW-1:0] p);
        return (p == VW'(V - 1)) ? '0 : p + VW'(1);
    endfunction

    assign nonempty = (count != '0);
    assign do_pop   = pop && nonempty;
    assign head_id  = slot[rd_ptr];

    always_comb begin
        for (int k = 0; k < V; k++) begin
            head_oh[k] = nonempty && (slot[rd_ptr] == VW'(k));
        end
    end

    // Reset loads every VC of the port; the queue starts full.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < V; k++) begin
                slot[k] <= VW'(k);
            end
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= CW'(V);
        end else begin
            if (push) begin
                slot[wr_ptr] <= push_id;
                wr_ptr       <= step_ptr(wr_ptr);
            end
            if (do_pop) begin
                rd_ptr <= step_ptr(rd_ptr);
            end
            unique case ({push, do_pop})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/fqva_rr_arb.sv
module fqva_rr_arb #(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);
    localparam int LW = (N > 1) ? $clog2(N) : 1;

    logic [LW-1:0] ptr;
    logic [LW-1:0] win;
    logic          found;

    always_comb begin
        int idx;
        gnt   = '0;
        win   = '0;
        found = 1'b0;
        for (int k = 0; k < N; k++) begin
            idx = int'(ptr) + k;
            if (idx >= N) idx = idx - N;
            if (!found && req[idx]) begin
                gnt[idx] = 1'b1;
                win      = LW'(idx);
                found    = 1'b1;
            end
        end
    end

    // Priority moves to the requester just after the last winner.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (found) begin
            ptr <= (win == LW'(N - 1)) ? '0 : win + LW'(1);
        end
    end
endmodule

// File: rtl/fqva_ivc_slot.sv
module fqva_ivc_slot
    import fqva_pkg::*;
#(
    parameter int PW = 2,
    parameter int VW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take,
    input  logic [PW-1:0] take_port,
    input  logic [VW-1:0] take_vc,
    input  logic          drop,
    output logic          busy,
    output logic [PW-1:0] cur_port,
    output logic [VW-1:0] cur_vc
);
    ivc_state_e state_q, state_d;

    // Next-state logic: T_GRANT and T_RELEASE.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            VS_IDLE:   if (take) state_d = VS_ACTIVE;
            VS_ACTIVE: if (drop) state_d = VS_IDLE;
            default:   state_d = VS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= VS_IDLE;
            cur_port <= '0;
            cur_vc   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == VS_IDLE && take) begin
                cur_port <= take_port;
                cur_vc   <= take_vc;
            end
        end
    end

    always_comb begin
        busy = (state_q == VS_ACTIVE);
    end
endmodule

// File: rtl/fqva_top.sv
module fqva_top #(
    parameter int P  = 4,
    parameter int V  = 4,
    parameter int N  = P * V,
    parameter int PW = $clog2(P),
    parameter int VW = $clog2(V)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N-1:0]    req_valid,
    input  logic [N*PW-1:0] req_port,
    input  logic [N-1:0]    tail_done,
    output logic [N-1:0]    grant,
    output logic [N*VW-1:0] grant_vc,
    output logic [N-1:0]    vc_busy,
    output logic [N*VW-1:0] vc_owned,
    output logic [P*V-1:0]  free_head_oh
);
    logic [N-1:0]  busy;
    logic [PW-1:0] cur_port [N];
    logic [VW-1:0] cur_vc   [N];
    logic [VW-1:0] head_id  [P];
    logic [P-1:0]  nonempty;
    logic [N-1:0]  arb_req  [P];
    logic [N-1:0]  arb_gnt  [P];
    logic [P-1:0]  q_pop;
    logic [P-1:0]  q_push;
    logic [VW-1:0] q_push_id [P];

    // Requests per port: idle input VCs only, and only when a VC is free.
    always_comb begin
        for (int p = 0; p < P; p++) begin
            for (int i = 0; i < N; i++) begin
                arb_req[p][i] = req_valid[i] && !busy[i] &&
                                (req_port[i*PW +: PW] == PW'(p)) && nonempty[p];
            end
        end
    end

    always_comb begin
        grant = '0;
        for (int p = 0; p < P; p++) begin
            grant   = grant | arb_gnt[p];
            q_pop[p] = |arb_gnt[p];
        end
    end

    always_comb begin
        for (int i = 0; i < N; i++) begin
            grant_vc[i*VW +: VW] = '0;
            for (int p = 0; p < P; p++) begin
                if (req_port[i*PW +: PW] == PW'(p)) grant_vc[i*VW +: VW] = head_id[p];
            end
        end
    end

    // Release path: each busy input VC returns the VC it holds.
    always_comb begin
        for (int p = 0; p < P; p++) begin
            q_push[p]    = 1'b0;
            q_push_id[p] = '0;
            for (int i = 0; i < N; i++) begin
                if (tail_done[i] && busy[i] && cur_port[i] == PW'(p)) begin
                    q_push[p]    = 1'b1;
                    q_push_id[p] = cur_vc[i];
                end
            end
        end
    end

    for (genvar p = 0; p < P; p++) begin : g_port
        fqva_free_queue #(.V(V), .VW(VW)) u_queue (
            .clk      (clk),
            .rst_n    (rst_n),
            .pop      (q_pop[p]),
            .push     (q_push[p]),
            .push_id  (q_push_id[p]),
            .head_id  (head_id[p]),
            .nonempty (nonempty[p]),
            .head_oh  (free_head_oh[p*V +: V])
        );
        fqva_rr_arb #(.N(N)) u_arb (
            .clk   (clk),
            .rst_n (rst_n),
            .req   (arb_req[p]),
            .gnt   (arb_gnt[p])
        );
    end

    for (genvar i = 0; i < N; i++) begin : g_ivc
        fqva_ivc_slot #(.PW(PW), .VW(VW)) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .take      (grant[i]),
            .take_port (req_port[i*PW +: PW]),
            .take_vc   (grant_vc[i*VW +: VW]),
            .drop      (tail_done[i]),
            .busy      (busy[i]),
            .cur_port  (cur_port[i]),
            .cur_vc    (cur_vc[i])
        );
        assign vc_owned[i*VW +: VW] = cur_vc[i];
    end

    assign vc_busy = busy;
endmodule

// File: rtl/fqva_checker.sv
module fqva_checker #(
    parameter int P  = 4,
    parameter int V  = 4,
    parameter int N  = P * V,
    parameter int PW = $clog2(P),
    parameter int VW = $clog2(V)
) (
    input logic            clk,
    input logic            rst_n,
    input logic [N-1:0]    req_valid,
    input logic [N*PW-1:0] req_port,
    input logic [N-1:0]    tail_done,
    input logic [N-1:0]    grant,
    input logic [N*VW-1:0] grant_vc,
    input logic [N-1:0]    vc_busy,
    input logic [N*VW-1:0] vc_owned,
    input logic [P*V-1:0]  free_head_oh
);
    logic [N-1:0] port_gnt [P];

    always_comb begin
        for (int p = 0; p < P; p++) begin
            for (int i = 0; i < N; i++) begin
                port_gnt[p][i] = grant[i] && (req_port[i*PW +: PW] == PW'(p));
            end
        end
    end

    for (genvar p = 0; p < P; p++) begin : g_pchk
        a_r2_head_onehot: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(free_head_oh[p*V +: V]));
        a_r4_one_grant_per_port: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(port_gnt[p]) <= 1);
        a_r4_empty_blocks_grant: assert property (@(posedge clk) disable iff (!rst_n)
            (free_head_oh[p*V +: V] == '0) |-> (port_gnt[p] == '0));
    end

    for (genvar i = 0; i < N; i++) begin : g_ichk
        a_r3_grant_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
            grant[i] |-> req_valid[i]);
        a_r9_busy_never_granted: assert property (@(posedge clk) disable iff (!rst_n)
            vc_busy[i] |-> !grant[i]);
        a_r5_owned_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
            grant[i] |=> (vc_busy[i] && vc_owned[i*VW +: VW] == $past(grant_vc[i*VW +: VW])));
        a_r6_idle_after_release: assert property (@(posedge clk) disable iff (!rst_n)
            (tail_done[i] && vc_busy[i]) |=> !vc_busy[i]);
    end
endmodule

bind fqva_top fqva_checker #(.P(P), .V(V)) u_fqva_checker (.*);

// File: tb/test_fqva_top.sv
module test_fqva_top;
    localparam int P  = 4;
    localparam int V  = 4;
    localparam int N  = P * V;
    localparam int PW = $clog2(P);
    localparam int VW = $clog2(V);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N-1:0]    req_valid = '0;
    logic [N*PW-1:0] req_port = '0;
    logic [N-1:0]    tail_done = '0;
    logic [N-1:0]    grant;
    logic [N*VW-1:0] grant_vc;
    logic [N-1:0]    vc_busy;
    logic [N*VW-1:0] vc_owned;
    logic [P*V-1:0]  free_head_oh;

    fqva_top #(.P(P), .V(V)) i_fqva_top (.*);

    always #10 clk = ~clk;

    int vectors = 0;
    int miscompares = 0;
    int coincide = 0;
    bit done = 0;

    int fq [P][$];
    bit m_busy [N];
    int m_port [N];
    int m_vc   [N];
    int m_ptr  [P];
    int win    [P];

    task automatic model_reset();
        for (int p = 0; p < P; p++) begin
            fq[p].delete();
            for (int k = 0; k < V; k++) fq[p].push_back(k);
            m_ptr[p] = 0;
        end
        for (int i = 0; i < N; i++) begin
            m_busy[i] = 0; m_port[i] = 0; m_vc[i] = 0;
        end
    endtask

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare outputs against the model, then advance the model by one edge.
    task automatic step();
        logic [N-1:0]   exp_g;
        logic [P*V-1:0] exp_oh;
        logic [N-1:0]   exp_b;
        #5;
        exp_g = '0; exp_oh = '0; exp_b = '0;
        for (int p = 0; p < P; p++) begin
            win[p] = -1;
            if (fq[p].size() > 0) begin
                exp_oh[p*V + fq[p][0]] = 1'b1;
                for (int k = 0; k < N; k++) begin
                    int idx;
                    idx = (m_ptr[p] + k) % N;
                    if (win[p] < 0 && req_valid[idx] && !m_busy[idx] &&
                        int'(req_port[idx*PW +: PW]) == p) win[p] = idx;
                end
                if (win[p] >= 0) exp_g[win[p]] = 1'b1;
            end
        end
        for (int i = 0; i < N; i++) exp_b[i] = m_busy[i];
        check(free_head_oh == exp_oh, "R2 R7 free head mask", free_head_oh, exp_oh);
        check(grant == exp_g, "R3 R4 R8 grant vector", grant, exp_g);
        check(vc_busy == exp_b, "R5 R6 busy vector", vc_busy, exp_b);
        for (int i = 0; i < N; i++) begin
            if (req_valid[i] && m_busy[i])
                check(!grant[i], "R9 busy requester ignored", grant[i], 0);
            if (m_busy[i])
                check(int'(vc_owned[i*VW +: VW]) == m_vc[i], "R5 owned vc",
                      vc_owned[i*VW +: VW], m_vc[i]);
        end
        for (int p = 0; p < P; p++) begin
            if (win[p] >= 0) begin
                int w;
                w = win[p];
                check(int'(grant_vc[w*VW +: VW]) == fq[p][0], "R3 granted vc",
                      grant_vc[w*VW +: VW], fq[p][0]);
            end
        end
        // Model update: grants pop heads, releases append to tails.
        for (int p = 0; p < P; p++) begin
            if (win[p] >= 0) begin
                m_busy[win[p]] = 1; m_port[win[p]] = p; m_vc[win[p]] = fq[p].pop_front();
                m_ptr[p] = (win[p] + 1) % N;
            end
        end
        for (int i = 0; i < N; i++) begin
            if (tail_done[i] && m_busy[i] && !(exp_g[i])) begin
                if (win[m_port[i]] >= 0) coincide++;
                fq[m_port[i]].push_back(m_vc[i]);
                m_busy[i] = 0;
            end
        end
    endtask

    task automatic drive_release(input int pct);
        tail_done = '0;
        for (int p = 0; p < P; p++) begin
            int cand[$];
            for (int i = 0; i < N; i++) if (m_busy[i] && m_port[i] == p) cand.push_back(i);
            if (cand.size() > 0 && int'($urandom % 100) < pct)
                tail_done[cand[$urandom % cand.size()]] = 1'b1;
        end
    endtask

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state.
        #5;
        check(vc_busy == '0, "R1 reset busy", vc_busy, 0);
        check(free_head_oh == {P{{(V-1){1'b0}}, 1'b1}}, "R1 reset head mask",
              free_head_oh, {P{{(V-1){1'b0}}, 1'b1}});
        // Contention: all input VCs want port 0; queue drains, then R4 holds off.
        for (int c = 0; c < V + 3; c++) begin
            @(negedge clk);
            req_valid = '1; req_port = '0; tail_done = '0;
            step();
        end
        check($countones(vc_busy) == V, "R4 grants limited by free VCs", $countones(vc_busy), V);
        // Free VCs one per cycle with requests still up: R6/R7.
        for (int c = 0; c < 3 * V; c++) begin
            @(negedge clk);
            drive_release(100);
            step();
        end
        // Random traffic.
        for (int c = 0; c < 4000; c++) begin
            @(negedge clk);
            for (int i = 0; i < N; i++) begin
                req_valid[i] = ($urandom % 100) < 45;
                req_port[i*PW +: PW] = PW'($urandom % P);
            end
            drive_release(40);
            step();
        end
        @(negedge clk);
        req_valid = '0; tail_done = '0;
        step();
        check(coincide > 0, "R7 same-cycle grant and release seen", coincide, 1);
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            done = 1;
            vectors++; miscompares++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule